// File: doc/BRIEF.md
# Memory Bank Extension Unit

This block widens a 16-bit word address so that it reaches a banked memory larger than 64K words. Each bank covers 32K words. The top bit of the incoming address picks the lower or upper half of the 64K space. The access type then picks one of six bank registers, and the low 15 address bits are placed below the 6-bit bank taken from that register. A memory cycle opens with a start strobe and closes with a memory-complete strobe. The unit captures the address and the bank at the start and holds the extended address unchanged until the cycle completes.

The lowest 32 word addresses form a register window that belongs to the processor. A cycle that falls in this window raises a register-access output for as long as the cycle lasts, so that external memory does not answer it. The six bank registers sit at window addresses 26 to 31 (octal 032 to 037). They are written with the data present at memory-complete and are read back combinationally while a window cycle is open.

Top module: `membank_xlat`

## Requirements
- R1: After reset all six bank registers are zero, `reg_acc` is low, `ext_addr` is zero and `rd_data` is zero.
- R2: In the cycle after an accepted start, `reg_acc` is 1 exactly when the captured address is below 32. It stays at that value until the cycle completes, and it is 0 whenever no cycle is open.
- R3: In the cycle after an accepted start, `ext_addr` equals {bank, word_addr[14:0]}, where the bank is the value that the selected register held at the start.
- R4: For a fetch (`acc_kind` = 1), the register at window address 27 (octal 033) is used when word_addr[15] = 0 and the register at 28 (octal 034) is used when word_addr[15] = 1.
- R5: For an indirect access (`acc_kind` = 2) and for plain data (`acc_kind` = 0, 5, 6 or 7), the register at 29 (octal 035) is used for the lower half and the register at 26 (octal 032) for the upper half.
- R6: A base-page access (`acc_kind` = 3) always uses the register at 30 (octal 036), and a DMA access (`acc_kind` = 4) always uses the register at 31 (octal 037), whatever the value of word_addr[15].
- R7: While a cycle is open, `ext_addr` and `reg_acc` do not change, and a start strobe during that time is ignored.
- R8: When `wr_en` is high at memory-complete of a cycle whose address is 26 to 31, the register at that address takes wr_data[5:0]. The new value is first used by the next memory cycle. A write to window addresses 0 to 25 changes no bank register.
- R9: While a cycle to addresses 26 to 31 is open, `rd_data` carries that register's value zero-extended to 16 bits. In every other cycle it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start strobe; accepted only when no cycle is open |
| cyc_done | input | 1 | Memory-complete; closes the open cycle |
| acc_kind | input | 3 | Access type: 0 data, 1 fetch, 2 indirect, 3 base page, 4 DMA |
| word_addr | input | 16 | Word address presented with the start strobe |
| wr_en | input | 1 | Register write, sampled at memory-complete |
| wr_data | input | 16 | Data written to a bank register |
| ext_addr | output | 21 | {bank[5:0], address[14:0]} held for the whole cycle |
| reg_acc | output | 1 | High while the open cycle targets the register window |
| rd_data | output | 16 | Zero-extended readback of the addressed bank register |

## Verification
The hardest situation to reach from the ports is a bank register changing between two cycles while the selector points at it. To see that a write only applies from the next cycle on, a window write has to be followed by an ordinary cycle whose kind and half select exactly that register. The random stream steers about a sixth of its addresses into the window and half of those become writes. Directed sequences add a start strobe fired during an open cycle, writes to the non-bank part of the window, and writes whose upper data bits are set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    AK_DATA  = 3'd0,
    AK_FETCH = 3'd1,
    AK_INDIR = 3'd2,
    AK_BASE  = 3'd3,
    AK_DMA   = 3'd4
  } acc_kind_e;

  // Slot index inside the bank file (slot n lives at window address base+n).
  // slot 0: indirect upper, 1: fetch lower, 2: fetch upper,
  // 3: indirect lower, 4: base page, 5: DMA
  function automatic logic [2:0] bank_slot(input logic [2:0] kind, input logic upper);
    logic [2:0] s;
    case (kind)
      AK_FETCH: s = upper ? 3'd2 : 3'd1;
      AK_BASE:  s = 3'd4;
      AK_DMA:   s = 3'd5;
      default:  s = upper ? 3'd0 : 3'd3;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mbx_bank_file.sv
module mbx_bank_file #(
  parameter int NREG = 6,
  parameter int BW   = 6,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [BW-1:0]   wbank,
  input  logic [IDXW-1:0] sel_idx,
  input  logic [IDXW-1:0] rb_idx,
  output logic [BW-1:0]   sel_bank,
  output logic [BW-1:0]   rb_bank
);

  logic [BW-1:0] regs [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = we && (widx == IDXW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      regs[g] <= '0;
      else if (hit[g]) regs[g] <= wbank;
    end
  end

  assign sel_bank = (int'(sel_idx) < NREG) ? regs[sel_idx] : '0;
  assign rb_bank  = (int'(rb_idx)  < NREG) ? regs[rb_idx]  : '0;

  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && int'(sel_idx) < NREG) |=> (sel_bank == $past(sel_bank)) || (sel_idx != $past(sel_idx)));

endmodule

// File: rtl/mbx_cycle_ctl.sv
module mbx_cycle_ctl #(
  parameter int AW       = 16,
  parameter int BW       = 6,
  parameter int REG_SPAN = 32,
  localparam int OFFW = AW - 1,
  localparam int XW   = BW + OFFW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          cyc_done,
  input  logic [AW-1:0] word_addr,
  input  logic [BW-1:0] bank_in,
  output logic          busy,
  output logic          start_fire,
  output logic          end_fire,
  output logic [AW-1:0] cap_addr,
  output logic [XW-1:0] ext_addr,
  output logic          reg_acc
);

  function automatic logic [XW-1:0] join_addr(input logic [BW-1:0] b, input logic [AW-1:0] a);
    return {b, a[OFFW-1:0]};
  endfunction

  function automatic logic in_window(input logic [AW-1:0] a);
    return a < AW'(REG_SPAN);
  endfunction

  assign start_fire = cyc_start && !busy;
  assign end_fire   = busy && cyc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cap_addr <= '0;
      ext_addr <= '0;
      reg_acc  <= 1'b0;
    end else if (start_fire) begin
      busy     <= 1'b1;
      cap_addr <= word_addr;
      ext_addr <= join_addr(bank_in, word_addr);
      reg_acc  <= in_window(word_addr);
    end else if (end_fire) begin
      busy    <= 1'b0;
      reg_acc <= 1'b0;
    end
  end

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_done) |=> $stable(ext_addr) && $stable(reg_acc));

  // R2
  reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_acc |-> busy);

  // R2
  reg_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> reg_acc == ($past(word_addr) < AW'(REG_SPAN)));

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> ext_addr[OFFW-1:0] == $past(word_addr[OFFW-1:0]));

endmodule

// File: rtl/membank_xlat.sv
module membank_xlat #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int BW       = 6,
  parameter int NREG     = 6,
  parameter int WIN_BASE = 26,
  parameter int REG_SPAN = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int XW   = BW + AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_start,
  input  logic          cyc_done,
  input  logic [2:0]    acc_kind,
  input  logic [AW-1:0] word_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [XW-1:0] ext_addr,
  output logic          reg_acc,
  output logic [DW-1:0] rd_data
);
  import mbx_pkg::*;

  logic            busy, start_fire, end_fire;
  logic [AW-1:0]   cap_addr, cap_off;
  logic            bank_hit;
  logic [IDXW-1:0] sel_idx, slot_idx;
  logic [BW-1:0]   sel_bank, rb_bank;
  logic            bank_we;

  assign sel_idx  = IDXW'(bank_slot(acc_kind, word_addr[AW-1]));
  assign cap_off  = cap_addr - AW'(WIN_BASE);
  assign bank_hit = (cap_addr >= AW'(WIN_BASE)) && (cap_addr < AW'(WIN_BASE + NREG));
  assign slot_idx = cap_off[IDXW-1:0];
  assign bank_we  = end_fire && wr_en && bank_hit;

  mbx_bank_file #(.NREG(NREG), .BW(BW)) u_banks (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .widx(slot_idx),
    .wbank(wr_data[BW-1:0]), .sel_idx(sel_idx), .rb_idx(slot_idx),
    .sel_bank(sel_bank), .rb_bank(rb_bank)
  );

  mbx_cycle_ctl #(.AW(AW), .BW(BW), .REG_SPAN(REG_SPAN)) u_cyc (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_done(cyc_done),
    .word_addr(word_addr), .bank_in(sel_bank), .busy(busy),
    .start_fire(start_fire), .end_fire(end_fire), .cap_addr(cap_addr),
    .ext_addr(ext_addr), .reg_acc(reg_acc)
  );

  assign rd_data = (busy && reg_acc && bank_hit) ? DW'(rb_bank) : '0;

  // R3
  bank_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> ext_addr[XW-1:AW-1] == $past(sel_bank));

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_acc |-> rd_data == '0);

  // R8
  write_only_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> reg_acc);

endmodule

// File: tb/sim_membank_xlat.sv
module sim_membank_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start = 1'b0, cyc_done = 1'b0, wr_en = 1'b0;
  logic [2:0]  acc_kind = '0;
  logic [15:0] word_addr = '0, wr_data = '0;
  logic [20:0] ext_addr;
  logic        reg_acc;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [5:0] model [26:31];

  always #2.5 clk = ~clk;

  membank_xlat u0 (.*);

  // Register (window address) that supplies the bank, from R4..R6
  function automatic int pick_reg(input logic [2:0] k, input logic [15:0] a);
    if (k == 3'd3) return 'o36;
    if (k == 3'd4) return 'o37;
    if (k == 3'd1) return a[15] ? 'o34 : 'o33;
    return a[15] ? 'o32 : 'o35;
  endfunction

  function automatic logic [20:0] exp_ext(input logic [2:0] k, input logic [15:0] a);
    return {model[pick_reg(k, a)], a[14:0]};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [15:0] a);
    if (a >= 16'd26 && a <= 16'd31) return {10'd0, model[a]};
    return 16'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full memory cycle; inputs move at negedge, outputs sampled at negedge.
  task automatic mem_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic w, input logic [15:0] d, input string tag);
    logic [20:0] e_ext;
    logic [15:0] e_rd;
    e_ext = exp_ext(k, a);
    e_rd  = exp_rd(a);
    acc_kind = k; word_addr = a; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; acc_kind = $urandom_range(0, 7); word_addr = $urandom;
    chk({tag, " R3 ext"}, 32'(ext_addr), 32'(e_ext));
    chk({tag, " R2 reg_acc"}, 32'(reg_acc), 32'(a < 16'd32));
    chk({tag, " R9 rd"}, 32'(rd_data), 32'(e_rd));
    cyc_done = 1'b1; wr_en = w; wr_data = d;
    @(negedge clk);
    cyc_done = 1'b0; wr_en = 1'b0;
    chk({tag, " R2 idle"}, 32'(reg_acc), 32'd0);
    if (w && a >= 16'd26 && a <= 16'd31) model[a] = d[5:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 26; i <= 31; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ext", 32'(ext_addr), 0);
    chk("R1 reg_acc", 32'(reg_acc), 0);
    chk("R1 rd", 32'(rd_data), 0);
    for (int r = 26; r <= 31; r++) mem_cycle(3'd0, 16'(r), 1'b0, 16'd0, "R1 zero");

    // R8 fill each bank register; upper data bits must be dropped
    for (int r = 26; r <= 31; r++)
      mem_cycle(3'd0, 16'(r), 1'b1, 16'hFFC0 | 16'(r - 20), "R8 fill");
    for (int r = 26; r <= 31; r++) mem_cycle(3'd2, 16'(r), 1'b0, 16'd0, "R8 readback");

    // R4 R5 R6 every kind on both halves
    for (int k = 0; k < 8; k++) begin
      mem_cycle(3'(k), 16'h1234, 1'b0, 0, "R4/R5/R6 low");
      mem_cycle(3'(k), 16'hC321, 1'b0, 0, "R4/R5/R6 high");
    end

    // R8 write to non-bank window addresses changes nothing
    mem_cycle(3'd0, 16'd5, 1'b1, 16'h003F, "R8 low window");
    mem_cycle(3'd0, 16'd25, 1'b1, 16'h003F, "R8 low window");
    for (int r = 26; r <= 31; r++) mem_cycle(3'd0, 16'(r), 1'b0, 0, "R8 untouched");

    // R8 new value used by the very next cycle
    mem_cycle(3'd0, 16'd27, 1'b1, 16'h002A, "R8 write fetch-low");
    mem_cycle(3'd1, 16'h0400, 1'b0, 0, "R8 next cycle");

    // R7 hold for a long cycle; stray start ignored
    acc_kind = 3'd4; word_addr = 16'h8001; cyc_start = 1'b1;
    @(negedge clk);
    begin
      logic [20:0] held;
      held = {model[31], 15'h0001};
      chk("R7 start", 32'(ext_addr), 32'(held));
      acc_kind = 3'd0; word_addr = 16'd3; cyc_start = 1'b1;
      repeat (4) begin
        @(negedge clk);
        chk("R7 hold ext", 32'(ext_addr), 32'(held));
        chk("R7 hold reg", 32'(reg_acc), 0);
      end
      cyc_start = 1'b0; cyc_done = 1'b1;
      @(negedge clk);
      cyc_done = 1'b0;
      chk("R7 closed", 32'(reg_acc), 0);
    end

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic w;
      a = $urandom;
      if ($urandom_range(0, 5) == 0) a = 16'($urandom_range(0, 31));
      w = $urandom_range(0, 1);
      mem_cycle(3'($urandom_range(0, 7)), a, w, 16'($urandom), "R3 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule